// File: doc/BRIEF.md
# Segment Load Sequencer

A vector unit-stride segment load moves records of several fields from memory into separate destination registers. This block turns one such request into an ordered stream of micro-operation descriptors. A downstream load/store pipe and a shuffle unit consume the stream. The block moves no data itself. It only works out what each micro-operation must do: which chunk of which field, how many elements, which internal staging buffer, which architectural destination register, and which byte address.

The stream has two phases. First, every field is loaded chunk by chunk into staging buffers. Then the same field/chunk walk is repeated, and each step emits a deinterleave descriptor that fills one destination register. A request with zero vector length produces a single no-op descriptor. A request whose register grouping cannot hold all its fields produces no descriptors. Instead it raises a one-cycle error pulse. Requests are taken over a valid/ready pair while the block is idle. Descriptors leave over a second valid/ready pair, one per handshake.

Top module: `seg_load_sequencer`

## Requirements
- R1: The field count is the 3-bit field code plus one (1..8). A chunk holds at most VLEN/(8·2^sew) elements, where sew code 0,1,2,3 means 8,16,32,64-bit elements. Each field is split into ceil(vl / chunk maximum) chunks, numbered from 0.
- R2: The element count of a load or deinterleave descriptor equals min(remaining, chunk maximum). Remaining starts at vl for every field and falls by the chunk maximum after each chunk.
- R3: When vl is 0, exactly one descriptor is emitted. Its kind is no-op, and its chunk, field, count and buffer index are all 0. Its destination is the base register and its address is the base address. It carries both markers.
- R4: Kind codes are 0 = no-op, 1 = load, 2 = deinterleave. All load descriptors come first, then all deinterleave descriptors. Within each phase the field index is the outer loop and the chunk index is the inner loop, both ascending. Nothing follows the last deinterleave.
- R5: Every load and deinterleave descriptor carries buffer index chunk + field × chunkCount.
- R6: A deinterleave descriptor's destination register is (base register + chunk + field × chunkCount) modulo 2^REG_W.
- R7: A load descriptor's byte address is (base + count × elementBytes × (chunk + field × chunkCount)) modulo 2^ADDR_W.
- R8: The grouping code is 0..3 for ×1, ×2, ×4, ×8 and 5..7 for fractional groupings. Code 4 is reserved. A request is illegal when the code is 4, or when code g is 0..3 and 2^g × fieldCount > 8. An accepted illegal request emits no descriptors. `cfg_err` goes high for exactly the one cycle after acceptance, and `req_ready` is low in that cycle.
- R9: Only the first descriptor of a request has `uop_first` set. Only the last has `uop_last` set.
- R10: `req_ready` is high only when no descriptor is pending and no error pulse is showing. While `uop_valid` is high and `uop_ready` is low, every descriptor output holds its value.
- R11: After reset, `req_ready` is 1 and both `uop_valid` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken this cycle when valid |
| req_vl | input | VL_W | Vector length in elements |
| req_sew | input | 2 | Element width code |
| req_nf | input | 3 | Field count minus one |
| req_lmul | input | 3 | Register grouping code |
| req_vd | input | REG_W | Base destination register |
| req_base | input | ADDR_W | Base byte address |
| uop_valid | output | 1 | Descriptor present |
| uop_ready | input | 1 | Descriptor consumed this cycle when valid |
| uop_kind | output | 2 | 0 no-op, 1 load, 2 deinterleave |
| uop_chunk | output | VL_W | Chunk index |
| uop_field | output | 3 | Field index |
| uop_count | output | VL_W | Elements in this chunk |
| uop_buf | output | VL_W+3 | Internal staging buffer index |
| uop_dest | output | REG_W | Destination register |
| uop_addr | output | ADDR_W | Load byte address |
| uop_first | output | 1 | First descriptor of the request |
| uop_last | output | 1 | Last descriptor of the request |
| cfg_err | output | 1 | One-cycle illegal-grouping pulse |

## Verification
Several properties are checked on every cycle. Descriptors hold steady under back-pressure. Requests are blocked while busy. The error pulse is one cycle long and never overlaps a descriptor. The no-op descriptor carries both markers and a zero count. Walk indices stay within the field and chunk counts, active chunks never have a zero element count, and the phases never go back from deinterleave to load. Other behaviour can only be shown by the bench's sweeps, which compare every descriptor against arithmetic expectations under irregular back-pressure. These cover the exact walk order, the ceiling chunk count, the shrinking last chunk, the buffer, destination and address arithmetic (including register and address wrap), and the legality decision over all 64 grouping and field-count pairs.

// File: rtl/seg_load_pkg.sv
// Shared types for the segment load sequencer.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package seg_load_pkg;

    // Descriptor kind as it appears on the uop_kind port.
    typedef enum logic [1:0] {
        KIND_NOP   = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_DEINT = 2'd2
    } uop_kind_e;

    // Walk state: idle, load phase, deinterleave phase, single no-op.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_DEINT = 2'd2,
        ST_NOP   = 2'd3
    } walk_state_e;

    // True when the grouping code cannot hold the requested field count.
    function automatic logic grouping_illegal(input logic [2:0] lmul,
                                              input logic [3:0] nfields);
        logic bad;
        case (lmul)
            3'd0:    bad = (nfields > 4'd8);
            3'd1:    bad = (nfields > 4'd4);
            3'd2:    bad = (nfields > 4'd2);
            3'd3:    bad = (nfields > 4'd1);
            3'd4:    bad = 1'b1;
            default: bad = 1'b0;
        endcase
        return bad;
    endfunction

endpackage

// File: rtl/seg_cfg_decode.sv
// Combinational request decoder.
// Derives field count, per-chunk element maximum, chunk count, legality
// and the zero-length case from a raw request.
// Assumes: VLEN is a power of two, VLEN >= 64, and VLEN/8 <= 2^VL_W.
module seg_cfg_decode
    import seg_load_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int VL_W = 8
) (
    input  logic [VL_W-1:0] vl_i,
    input  logic [1:0]      sew_i,
    input  logic [2:0]      nf_i,
    input  logic [2:0]      lmul_i,
    output logic [3:0]      nfields_o,
    output logic [VL_W:0]   cmax_o,
    output logic [VL_W-1:0] ccnt_o,
    output logic            illegal_o,
    output logic            zero_o
);
    localparam int LOG2_VLEN  = $clog2(VLEN);
    localparam int BASE_SHIFT = LOG2_VLEN - 3;

    logic [VL_W:0] round_up;
    int unsigned   shift;

    // Chunk geometry: maximum per chunk and ceiling chunk count.
    always_comb begin
        shift     = BASE_SHIFT - int'(sew_i);
        cmax_o    = (VL_W+1)'(1) << shift;
        round_up  = {1'b0, vl_i} + cmax_o - (VL_W+1)'(1);
        ccnt_o    = VL_W'(round_up >> shift);
    end

    // Field count, legality and zero-length detection.
    always_comb begin
        nfields_o = {1'b0, nf_i} + 4'd1;
        illegal_o = grouping_illegal(lmul_i, nfields_o);
        zero_o    = (vl_i == '0);
    end

endmodule

// File: rtl/seg_walk.sv
// Field/chunk walk engine.
// Steps through load phase then deinterleave phase, field outer and
// chunk inner, tracking remaining elements per field.
// Assumes: start/start_nop arrive only while idle; the configuration
// inputs other than start_vl_i are held stable by the owner while busy.
module seg_walk
    import seg_load_pkg::*;
#(
    parameter int VL_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            start_nop_i,
    input  logic [VL_W-1:0] start_vl_i,
    input  logic [VL_W-1:0] vl_i,
    input  logic [2:0]      nf_last_i,
    input  logic [VL_W-1:0] cc_last_i,
    input  logic [VL_W:0]   cmax_i,
    input  logic            adv_i,
    output walk_state_e     state_o,
    output logic [2:0]      field_o,
    output logic [VL_W-1:0] chunk_o,
    output logic [VL_W-1:0] rem_o
);
    walk_state_e     state_q;
    logic [2:0]      field_q;
    logic [VL_W-1:0] chunk_q;
    logic [VL_W-1:0] rem_q;

    // Advance the walk one step per consumed descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            field_q <= '0;
            chunk_q <= '0;
            rem_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_nop_i) begin
                        state_q <= ST_NOP;
                        field_q <= '0;
                        chunk_q <= '0;
                        rem_q   <= '0;
                    end else if (start_i) begin
                        state_q <= ST_LOAD;
                        field_q <= '0;
                        chunk_q <= '0;
                        rem_q   <= start_vl_i;
                    end
                end
                ST_NOP: begin
                    if (adv_i) state_q <= ST_IDLE;
                end
                default: begin
                    if (adv_i) begin
                        if (chunk_q != cc_last_i) begin
                            chunk_q <= chunk_q + VL_W'(1);
                            rem_q   <= VL_W'({1'b0, rem_q} - cmax_i);
                        end else begin
                            chunk_q <= '0;
                            rem_q   <= vl_i;
                            if (field_q != nf_last_i) begin
                                field_q <= field_q + 3'd1;
                            end else begin
                                field_q <= '0;
                                state_q <= (state_q == ST_LOAD) ? ST_DEINT : ST_IDLE;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign state_o = state_q;
    assign field_o = field_q;
    assign chunk_o = chunk_q;
    assign rem_o   = rem_q;

    // Walk indices stay inside the configured field and chunk counts.
    assert_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD || state_q == ST_DEINT) |->
            (field_q <= nf_last_i && chunk_q <= cc_last_i));

    // Once deinterleaving starts, loading never resumes for the request.
    assert_phase_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEINT) |=> (state_q != ST_LOAD));

    // An active chunk always has elements left to cover.
    assert_rem_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD || state_q == ST_DEINT) |-> (rem_q != '0));

endmodule

// File: rtl/seg_uop_fmt.sv
// Descriptor formatter.
// Turns the walk position into kind, element count, buffer index,
// destination register, byte address and first/last markers.
// Assumes: inputs come from registers, so outputs settle within the cycle.
module seg_uop_fmt
    import seg_load_pkg::*;
#(
    parameter int VL_W   = 8,
    parameter int REG_W  = 5,
    parameter int ADDR_W = 32
) (
    input  walk_state_e       state_i,
    input  logic [2:0]        field_i,
    input  logic [VL_W-1:0]   chunk_i,
    input  logic [VL_W-1:0]   rem_i,
    input  logic [VL_W:0]     cmax_i,
    input  logic [VL_W-1:0]   cc_last_i,
    input  logic [2:0]        nf_last_i,
    input  logic [1:0]        sew_i,
    input  logic [REG_W-1:0]  vd_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [1:0]        kind_o,
    output logic [VL_W-1:0]   count_o,
    output logic [VL_W+2:0]   buf_o,
    output logic [REG_W-1:0]  dest_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              first_o,
    output logic              last_o
);
    localparam int BUF_W  = VL_W + 3;
    localparam int SPAN_W = VL_W + 3;
    localparam int PROD_W = SPAN_W + BUF_W;

    logic [BUF_W-1:0]  ccnt;
    logic [SPAN_W-1:0] span;
    logic [PROD_W-1:0] offset;

    // Kind from the walk phase.
    always_comb begin
        case (state_i)
            ST_LOAD:  kind_o = KIND_LOAD;
            ST_DEINT: kind_o = KIND_DEINT;
            default:  kind_o = KIND_NOP;
        endcase
    end

    // Element count, linear buffer index and destination register.
    always_comb begin
        count_o = ({1'b0, rem_i} < cmax_i) ? rem_i : VL_W'(cmax_i);
        ccnt    = BUF_W'(cc_last_i) + BUF_W'(1);
        buf_o   = BUF_W'(chunk_i) + BUF_W'(field_i) * ccnt;
        dest_o  = vd_i + REG_W'(buf_o);
    end

    // Byte address: chunk byte span scaled by the linear index.
    always_comb begin
        span   = SPAN_W'(count_o) << sew_i;
        offset = PROD_W'(span) * PROD_W'(buf_o);
        addr_o = base_i + ADDR_W'(offset);
    end

    // First and last markers of the request's descriptor stream.
    always_comb begin
        first_o = (state_i == ST_NOP) ||
                  (state_i == ST_LOAD && field_i == 3'd0 && chunk_i == '0);
        last_o  = (state_i == ST_NOP) ||
                  (state_i == ST_DEINT && field_i == nf_last_i && chunk_i == cc_last_i);
    end

endmodule

// File: rtl/seg_load_sequencer.sv
// Segment load micro-op sequencer, top level.
// Accepts one request while idle, checks grouping legality, latches the
// decoded configuration and streams descriptors over valid/ready.
// Assumes: synchronous active-low reset; descriptor outputs are
// meaningful only while uop_valid is high.
module seg_load_sequencer
    import seg_load_pkg::*;
#(
    parameter int VLEN   = 128,
    parameter int VL_W   = 8,
    parameter int REG_W  = 5,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VL_W-1:0]   req_vl,
    input  logic [1:0]        req_sew,
    input  logic [2:0]        req_nf,
    input  logic [2:0]        req_lmul,
    input  logic [REG_W-1:0]  req_vd,
    input  logic [ADDR_W-1:0] req_base,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [1:0]        uop_kind,
    output logic [VL_W-1:0]   uop_chunk,
    output logic [2:0]        uop_field,
    output logic [VL_W-1:0]   uop_count,
    output logic [VL_W+2:0]   uop_buf,
    output logic [REG_W-1:0]  uop_dest,
    output logic [ADDR_W-1:0] uop_addr,
    output logic              uop_first,
    output logic              uop_last,
    output logic              cfg_err
);
    logic [3:0]        d_nfields;
    logic [VL_W:0]     d_cmax;
    logic [VL_W-1:0]   d_ccnt;
    logic              d_illegal;
    logic              d_zero;

    logic [VL_W-1:0]   vl_q;
    logic [1:0]        sew_q;
    logic [2:0]        nf_last_q;
    logic [VL_W-1:0]   cc_last_q;
    logic [VL_W:0]     cmax_q;
    logic [REG_W-1:0]  vd_q;
    logic [ADDR_W-1:0] base_q;
    logic              err_q;

    walk_state_e       w_state;
    logic [2:0]        w_field;
    logic [VL_W-1:0]   w_chunk;
    logic [VL_W-1:0]   w_rem;

    logic              accept;
    logic              go_walk;
    logic              go_nop;
    logic              adv;

    seg_cfg_decode #(.VLEN(VLEN), .VL_W(VL_W)) u_decode (
        .vl_i      (req_vl),
        .sew_i     (req_sew),
        .nf_i      (req_nf),
        .lmul_i    (req_lmul),
        .nfields_o (d_nfields),
        .cmax_o    (d_cmax),
        .ccnt_o    (d_ccnt),
        .illegal_o (d_illegal),
        .zero_o    (d_zero)
    );

    // Handshake qualifiers for request intake and descriptor advance.
    always_comb begin
        req_ready = (w_state == ST_IDLE) && !err_q;
        accept    = req_valid && req_ready;
        go_walk   = accept && !d_illegal && !d_zero;
        go_nop    = accept && !d_illegal && d_zero;
        uop_valid = (w_state != ST_IDLE);
        adv       = uop_valid && uop_ready;
    end

    // Latch the decoded configuration when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q      <= '0;
            sew_q     <= '0;
            nf_last_q <= '0;
            cc_last_q <= '0;
            cmax_q    <= '0;
            vd_q      <= '0;
            base_q    <= '0;
        end else if (accept) begin
            vl_q      <= req_vl;
            sew_q     <= req_sew;
            nf_last_q <= 3'(d_nfields - 4'd1);
            cc_last_q <= d_ccnt - VL_W'(1);
            cmax_q    <= d_cmax;
            vd_q      <= req_vd;
            base_q    <= req_base;
        end
    end

    // One-cycle error pulse for an accepted illegal request.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= accept && d_illegal;
    end

    assign cfg_err = err_q;

    seg_walk #(.VL_W(VL_W)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (go_walk),
        .start_nop_i (go_nop),
        .start_vl_i  (req_vl),
        .vl_i        (vl_q),
        .nf_last_i   (nf_last_q),
        .cc_last_i   (cc_last_q),
        .cmax_i      (cmax_q),
        .adv_i       (adv),
        .state_o     (w_state),
        .field_o     (w_field),
        .chunk_o     (w_chunk),
        .rem_o       (w_rem)
    );

    seg_uop_fmt #(.VL_W(VL_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_fmt (
        .state_i   (w_state),
        .field_i   (w_field),
        .chunk_i   (w_chunk),
        .rem_i     (w_rem),
        .cmax_i    (cmax_q),
        .cc_last_i (cc_last_q),
        .nf_last_i (nf_last_q),
        .sew_i     (sew_q),
        .vd_i      (vd_q),
        .base_i    (base_q),
        .kind_o    (uop_kind),
        .count_o   (uop_count),
        .buf_o     (uop_buf),
        .dest_o    (uop_dest),
        .addr_o    (uop_addr),
        .first_o   (uop_first),
        .last_o    (uop_last)
    );

    assign uop_chunk = w_chunk;
    assign uop_field = w_field;

    // A stalled descriptor keeps every field unchanged.
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_kind) &&
            $stable(uop_chunk) && $stable(uop_field) && $stable(uop_count) &&
            $stable(uop_buf) && $stable(uop_dest) && $stable(uop_addr) &&
            $stable(uop_first) && $stable(uop_last)));

    // No new request can enter while descriptors are pending.
    assert_busy_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> !req_ready);

    // The error indication lasts exactly one cycle.
    assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !cfg_err);

    // An error never coincides with a descriptor.
    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !uop_valid);

    // The zero-length no-op is both first and last and carries no elements.
    assert_nop_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_kind == 2'd0) |-> (uop_first && uop_last && uop_count == '0));

endmodule

// File: tb/seg_load_sequencer_bench.sv
module seg_load_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VLEN   = 128;
    localparam int VL_W   = 8;
    localparam int REG_W  = 5;
    localparam int ADDR_W = 32;

    logic              clk;
    logic              rst_n;
    logic              req_valid;
    logic              req_ready;
    logic [VL_W-1:0]   req_vl;
    logic [1:0]        req_sew;
    logic [2:0]        req_nf;
    logic [2:0]        req_lmul;
    logic [REG_W-1:0]  req_vd;
    logic [ADDR_W-1:0] req_base;
    logic              uop_valid;
    logic              uop_ready;
    logic [1:0]        uop_kind;
    logic [VL_W-1:0]   uop_chunk;
    logic [2:0]        uop_field;
    logic [VL_W-1:0]   uop_count;
    logic [VL_W+2:0]   uop_buf;
    logic [REG_W-1:0]  uop_dest;
    logic [ADDR_W-1:0] uop_addr;
    logic              uop_first;
    logic              uop_last;
    logic              cfg_err;

    int errors = 0;
    int checks = 0;

    seg_load_sequencer #(.VLEN(VLEN), .VL_W(VL_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_seg_load_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vl(req_vl), .req_sew(req_sew), .req_nf(req_nf), .req_lmul(req_lmul),
        .req_vd(req_vd), .req_base(req_base), .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_kind(uop_kind), .uop_chunk(uop_chunk), .uop_field(uop_field),
        .uop_count(uop_count), .uop_buf(uop_buf), .uop_dest(uop_dest),
        .uop_addr(uop_addr), .uop_first(uop_first), .uop_last(uop_last), .cfg_err(cfg_err)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint snap();
        return {uop_kind, uop_chunk, uop_field, uop_count, uop_buf, uop_dest, uop_first, uop_last}
               ^ (longint'(uop_addr) << 20);
    endfunction

    // Legal request: every descriptor compared against arithmetic expectations.
    task automatic run_legal(input int vl, input int sew, input int nf, input int lmul,
                             input int vd, input longint base);
        int cmax, nfl, cc, total, idx, guard;
        bit held;
        longint held_val;
        cmax  = (VLEN / 8) >> sew;
        nfl   = nf + 1;
        cc    = (vl + cmax - 1) / cmax;
        total = (vl == 0) ? 1 : 2 * nfl * cc;
        idx   = 0;
        guard = 0;
        held  = 0;
        held_val = 0;
        check(req_ready == 1'b1, "R10", "ready when idle", req_ready, 1);
        req_valid = 1'b1;
        req_vl = VL_W'(vl); req_sew = 2'(sew); req_nf = 3'(nf); req_lmul = 3'(lmul);
        req_vd = REG_W'(vd); req_base = ADDR_W'(base);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        while (idx < total && guard < 5000) begin
            uop_ready = ((guard * 3 + vl + nf) % 4) != 1;
            guard++;
            if (!uop_valid) begin
                check(1'b0, "R4", "valid dropped before stream end", idx, total);
                break;
            end
            if (held) check(snap() == held_val, "R10", "stalled descriptor changed", snap(), held_val);
            check(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
            if (uop_ready) begin
                int p, r, f, c, rem, cnt, bufi, kind, dest;
                longint addr;
                bit first, last;
                if (vl == 0) begin
                    kind = 0; f = 0; c = 0; cnt = 0; bufi = 0; dest = vd % 32;
                    addr = base; first = 1; last = 1;
                    check(uop_kind == 2'd0, "R3", "no-op kind", uop_kind, 0);
                    check(uop_addr == ADDR_W'(base), "R3", "no-op address", uop_addr, base);
                    check(uop_dest == REG_W'(vd), "R3", "no-op dest", uop_dest, vd);
                end else begin
                    p = idx / (nfl * cc);
                    r = idx % (nfl * cc);
                    f = r / cc;
                    c = r % cc;
                    rem = vl - c * cmax;
                    cnt = (rem < cmax) ? rem : cmax;
                    bufi = c + f * cc;
                    kind = (p == 0) ? 1 : 2;
                    dest = (vd + bufi) % 32;
                    addr = (base + longint'(cnt) * (longint'(1) << sew) * bufi) & 64'hFFFF_FFFF;
                    first = (idx == 0);
                    last = (idx == total - 1);
                    check(uop_kind == 2'(kind), "R4", "kind", uop_kind, kind);
                    if (kind == 2) check(uop_dest == REG_W'(dest), "R6", "dest", uop_dest, dest);
                    else check(uop_addr == ADDR_W'(addr), "R7", "address", uop_addr, addr);
                end
                check(uop_chunk == VL_W'(c), "R1", "chunk index", uop_chunk, c);
                check(uop_field == 3'(f), "R4", "field index", uop_field, f);
                check(uop_count == VL_W'(cnt), "R2", "element count", uop_count, cnt);
                check(uop_buf == (VL_W+3)'(bufi), "R5", "buffer index", uop_buf, bufi);
                check(uop_first == first, "R9", "first marker", uop_first, first);
                check(uop_last == last, "R9", "last marker", uop_last, last);
                idx++;
                held = 0;
            end else begin
                held = 1;
                held_val = snap();
            end
            @(posedge clk); @(negedge clk);
        end
        uop_ready = 1'b0;
        check(idx == total, "R1", "descriptor total", idx, total);
        check(uop_valid == 1'b0, "R4", "nothing after last", uop_valid, 0);
        check(req_ready == 1'b1, "R10", "ready after stream", req_ready, 1);
    endtask

    // Illegal request: one error pulse, no descriptors.
    task automatic run_illegal(input int nf, input int lmul);
        req_valid = 1'b1;
        req_vl = VL_W'(5); req_sew = 2'd1; req_nf = 3'(nf); req_lmul = 3'(lmul);
        req_vd = REG_W'(3); req_base = 32'h400;
        @(posedge clk); @(negedge clk);
        check(cfg_err == 1'b1, "R8", "error pulse high", cfg_err, 1);
        check(uop_valid == 1'b0, "R8", "no descriptor on error", uop_valid, 0);
        check(req_ready == 1'b0, "R8", "ready low in pulse", req_ready, 0);
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check(cfg_err == 1'b0, "R8", "error pulse ends", cfg_err, 0);
        check(uop_valid == 1'b0, "R8", "still no descriptor", uop_valid, 0);
        check(req_ready == 1'b1, "R8", "ready after pulse", req_ready, 1);
    endtask

    initial begin
        int vls[5];
        vls = '{0, 1, 7, 16, 37};
        rst_n = 1'b0; req_valid = 1'b0; uop_ready = 1'b0;
        req_vl = '0; req_sew = '0; req_nf = '0; req_lmul = '0; req_vd = '0; req_base = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b1, "R11", "reset req_ready", req_ready, 1);
        check(uop_valid == 1'b0, "R11", "reset uop_valid", uop_valid, 0);
        check(cfg_err == 1'b0, "R11", "reset cfg_err", cfg_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Main sweep: all widths, all field counts, several lengths.
        for (int s = 0; s < 4; s++)
            for (int n = 0; n < 8; n++)
                for (int v = 0; v < 5; v++)
                    run_legal(vls[v], s, n, 0, (n * 7 + s * 11 + 13) % 32,
                              (v == 4) ? 64'hFFFF_FF00 : 64'h1000 + s * 64'h100);

        // Legality sweep over every grouping code and field count.
        for (int g = 0; g < 8; g++)
            for (int n = 0; n < 8; n++) begin
                bit bad;
                bad = (g == 4) || (g < 4 && ((n + 1) << g) > 8);
                if (bad) run_illegal(n, g);
                else run_legal(3, 2, n, g, 30, 64'h2000);
            end

        // Back-to-back illegal then legal request.
        run_illegal(7, 3);
        run_legal(9, 0, 1, 7, 31, 64'h80);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule